// File: doc/BRIEF.md
# Programmable Modulo Interval Timer

This block is an 8-bit up-counter that runs from zero to a programmed terminal value, rolls back to zero, and raises a sticky overflow flag on every rollover. An interrupt request follows the flag when the enable bit is set. Software uses it either as a periodic tick source or to pace a loop: restart the count, do variable-length work, then poll the flag to finish the period on time.

The count steps on a selectable source: every bus clock, or rising or falling edges of an external timer pin that is brought into the clock domain through a two-flop synchroniser. A power-of-two prescaler (divide by 1 to 256) sits between the source and the counter. Four byte registers on a simple single-cycle bus give access to control and status, clock configuration, the live count and the terminal value. A stop bit freezes the count without losing it. A restart bit zeroes the count and the prescaler together.

Top module: `mtim_top`

## Requirements
- R1: With terminal value M in 1..255, prescale 0 and the bus clock selected, the count after k counting edges is k mod (M+1). With prescale p the count is floor(k / 2^p) mod (M+1). Edges are counted from the edge that takes a write of the restart bit with the stop bit clear.
- R2: A terminal value of 0 makes the counter cycle through all 256 values, so the count is floor(k / 2^p) mod 256.
- R3: The overflow flag (status bit 7) becomes 1 on the edge where the count rolls over to 0. The output `irq` is 1 exactly when both the flag and the interrupt enable (status bit 6) are 1.
- R4: Writing 0 to status bit 7 clears the flag only after a read of the status register that returned the flag as 1. Such a write without that earlier read leaves the flag set.
- R5: Any write to the terminal-value register clears the flag.
- R6: Writing 1 to the restart bit (status bit 5) sets the count to 0, clears the flag and restarts the prescaler. The bit always reads back as 0.
- R7: While the stop bit (status bit 4) is 1 the count keeps its value. After the bit is cleared, counting continues upward from that held value.
- R8: Clock select (clock register bits 5:4) works as follows: 00 counts bus clocks, 10 counts falling edges of `ext_clk`, 11 counts rising edges of `ext_clk`, and 01 counts nothing.
- R9: Prescale (clock register bits 3:0) divides the selected source by 2^p for p from 0 to 8. Codes 9 to 15 act as 8.
- R10: The register map is 0 for status/control, 1 for clock configuration, 2 for the count (read-only, writes ignored) and 3 for the terminal value. After reset these read as 0x10, 0x00, 0x00 and 0x00, and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read (with bus_sel) |
| bus_addr | input | 2 | Register index |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| ext_clk | input | 1 | External timer clock pin, asynchronous |
| irq | output | 1 | Overflow interrupt request |

## Verification
The bench sweeps several terminal values, including 0, 1 and 255, against prescale codes 0 to 3, 8 and 15. It compares the count and `irq` on every cycle with the floor-and-modulo formula. An off-by-one terminal compare would show up as a period of M or M+2. A prescaler that fails to clamp would never count at code 15. The flag-clearing paths are tested separately, including a write of zero with no read before it: a design that drops the read-arming step clears the flag too early. The stop/resume test catches a counter that restarts from zero instead of continuing. The external-pin tests give a half-pulse to the wrong-edge mode, which catches a design that counts both edges or swaps the polarities.

// File: rtl/mtim_pkg.sv
package mtim_pkg;

  localparam int TMR_W    = 8;
  localparam int PS_MAX   = 8;
  localparam int PS_FLD_W = 4;

  localparam logic [1:0] ADDR_CTL = 2'd0;
  localparam logic [1:0] ADDR_CLK = 2'd1;
  localparam logic [1:0] ADDR_CNT = 2'd2;
  localparam logic [1:0] ADDR_MOD = 2'd3;

  typedef enum logic [1:0] {
    SRC_BUS  = 2'b00,
    SRC_NONE = 2'b01,
    SRC_FALL = 2'b10,
    SRC_RISE = 2'b11
  } src_e;

  // Clamp the prescale code to the supported maximum.
  function automatic logic [PS_FLD_W-1:0] ps_clamp(input logic [PS_FLD_W-1:0] ps);
    return (ps > PS_FLD_W'(PS_MAX)) ? PS_FLD_W'(PS_MAX) : ps;
  endfunction

  // Low-bit mask for a divide by 2^ps.
  function automatic logic [PS_MAX-1:0] ps_mask(input logic [PS_FLD_W-1:0] ps);
    return ~({PS_MAX{1'b1}} << ps_clamp(ps));
  endfunction

  // Last value before rollover: 0 means full range.
  function automatic logic [TMR_W-1:0] term_value(input logic [TMR_W-1:0] m);
    return (m == '0) ? {TMR_W{1'b1}} : m;
  endfunction

endpackage

// File: rtl/mtim_edge_sync.sv
module mtim_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic s1, s2, prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1   <= 1'b0;
      s2   <= 1'b0;
      prev <= 1'b0;
    end else begin
      s1   <= pin;
      s2   <= s1;
      prev <= s2;
    end
  end

  assign rise = s2 & ~prev;
  assign fall = ~s2 & prev;
endmodule

// File: rtl/mtim_prescaler.sv
module mtim_prescaler
  import mtim_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                src_tick,
  input  logic                restart,
  input  logic                hold,
  input  logic [PS_FLD_W-1:0] ps,
  output logic                cnt_tick
);
  logic [PS_MAX-1:0] pc;
  logic [PS_MAX-1:0] mask;

  assign mask     = ps_mask(ps);
  assign cnt_tick = src_tick & ~hold & ~restart & ((pc & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pc <= '0;
    else if (restart)          pc <= '0;
    else if (src_tick && !hold) pc <= pc + 1'b1;
  end
endmodule

// File: rtl/mtim_counter.sv
module mtim_counter
  import mtim_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clear,
  input  logic [TMR_W-1:0] modv,
  output logic [TMR_W-1:0] count,
  output logic             wrap
);
  logic at_end;

  assign at_end = (count == term_value(modv)) || (count == {TMR_W{1'b1}});
  assign wrap   = tick & ~clear & at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count <= '0;
    else if (clear) count <= '0;
    else if (tick)  count <= at_end ? '0 : count + 1'b1;
  end
endmodule

// File: rtl/mtim_top.sv
module mtim_top
  import mtim_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       ext_clk,
  output logic       irq
);
  // control and configuration state
  logic                flag_q, ie_q, stop_q, arm_q;
  logic [1:0]          sel_q;
  logic [PS_FLD_W-1:0] ps_q;
  logic [TMR_W-1:0]    mod_q;

  // named internal events
  logic ctl_wr, clk_wr, mod_wr, ctl_rd, trst_wr, zero_wr;
  logic pin_rise, pin_fall, src_tick, tick, wrap_evt;
  logic [TMR_W-1:0] count;

  assign ctl_wr  = bus_sel & bus_wr & (bus_addr == ADDR_CTL);
  assign clk_wr  = bus_sel & bus_wr & (bus_addr == ADDR_CLK);
  assign mod_wr  = bus_sel & bus_wr & (bus_addr == ADDR_MOD);
  assign ctl_rd  = bus_sel & ~bus_wr & (bus_addr == ADDR_CTL);
  assign trst_wr = ctl_wr & bus_wdata[5];
  assign zero_wr = ctl_wr & ~bus_wdata[7] & arm_q;

  mtim_edge_sync u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .pin  (ext_clk),
    .rise (pin_rise),
    .fall (pin_fall)
  );

  always_comb begin
    unique case (src_e'(sel_q))
      SRC_BUS:  src_tick = 1'b1;
      SRC_FALL: src_tick = pin_fall;
      SRC_RISE: src_tick = pin_rise;
      default:  src_tick = 1'b0;
    endcase
  end

  mtim_prescaler u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_tick(src_tick),
    .restart (trst_wr),
    .hold    (stop_q),
    .ps      (ps_q),
    .cnt_tick(tick)
  );

  mtim_counter u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick),
    .clear(trst_wr),
    .modv (mod_q),
    .count(count),
    .wrap (wrap_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q   <= 1'b0;
      stop_q <= 1'b1;
      sel_q  <= 2'b00;
      ps_q   <= '0;
      mod_q  <= '0;
    end else begin
      if (ctl_wr) begin
        ie_q   <= bus_wdata[6];
        stop_q <= bus_wdata[4];
      end
      if (clk_wr) begin
        sel_q <= bus_wdata[5:4];
        ps_q  <= bus_wdata[PS_FLD_W-1:0];
      end
      if (mod_wr) mod_q <= bus_wdata[TMR_W-1:0];
    end
  end

  // overflow flag with its three clearing paths
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  flag_q <= 1'b0;
    else if (trst_wr)            flag_q <= 1'b0;
    else if (wrap_evt)           flag_q <= 1'b1;
    else if (mod_wr || zero_wr)  flag_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 arm_q <= 1'b0;
    else if (ctl_wr)            arm_q <= 1'b0;
    else if (ctl_rd && flag_q)  arm_q <= 1'b1;
  end

  always_comb begin
    unique case (bus_addr)
      ADDR_CTL: bus_rdata = {flag_q, ie_q, 1'b0, stop_q, 4'b0000};
      ADDR_CLK: bus_rdata = {2'b00, sel_q, ps_q};
      ADDR_CNT: bus_rdata = count;
      default:  bus_rdata = mod_q;
    endcase
  end

  assign irq = flag_q & ie_q;
endmodule

// File: rtl/mtim_checker.sv
module mtim_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       wrap_evt,
  input logic       flag_q,
  input logic       trst_wr,
  input logic       mod_wr,
  input logic       stop_q,
  input logic       tick,
  input logic [7:0] count
);
  assert_wrap_sets_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> flag_q);

  assert_flag_only_on_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(wrap_evt));

  assert_restart_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trst_wr |=> (count == 8'd0) && !flag_q);

  assert_mod_write_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_wr && !wrap_evt && !trst_wr) |=> !flag_q);

  assert_stop_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q && !trst_wr) |=> $stable(count));

  assert_step_by_one_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wrap_evt && !trst_wr) |=> count == $past(count) + 8'd1);
endmodule

bind mtim_top mtim_checker i_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wrap_evt(wrap_evt),
  .flag_q  (flag_q),
  .trst_wr (trst_wr),
  .mod_wr  (mod_wr),
  .stop_q  (stop_q),
  .tick    (tick),
  .count   (count)
);

// File: tb/test_mtim_top.sv
`timescale 1ns/1ps
module test_mtim_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       ext_clk = 1'b0;
  logic       irq;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mtim_top i_mtim_top (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_clk(ext_clk), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  // Wait k counting edges from the current negedge, then read.
  task automatic peek(input int k, input logic [1:0] a, output logic [7:0] v);
    repeat (k) @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic sweep(input int m, input int ps, input int kmax);
    int per, psc;
    per = (m == 0) ? 256 : m + 1;
    psc = (ps > 8) ? 8 : ps;
    wr(2'd3, 8'(m));
    wr(2'd1, 8'(ps));
    wr(2'd0, 8'h60);            // enable irq, restart, run
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 2'd2;
    for (int k = 0; k < kmax; k++) begin
      int t;
      t = k >> psc;
      #1;
      check(m == 0 ? "R2 count" : (ps > 3 ? "R9 count" : "R1 count"), bus_rdata, t % per);
      check("R3 irq", irq, (t >= per) ? 1 : 0);
      @(negedge clk);
    end
    bus_sel = 1'b0;
  endtask

  task automatic pulse_pin(input int n);
    for (int i = 0; i < n; i++) begin
      ext_clk = 1'b1; repeat (5) @(negedge clk);
      ext_clk = 1'b0; repeat (5) @(negedge clk);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, v2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset values
    peek(0, 2'd0, v); check("R10 ctl reset", v, 8'h10);
    peek(0, 2'd1, v); check("R10 clk reset", v, 8'h00);
    peek(0, 2'd2, v); check("R10 cnt reset", v, 8'h00);
    peek(0, 2'd3, v); check("R10 mod reset", v, 8'h00);
    check("R10 irq reset", irq, 0);

    // R1, R2, R9 sweeps with R3 irq
    sweep(1, 0, 20);
    sweep(2, 0, 20);
    sweep(3, 2, 40);
    sweep(5, 1, 30);
    sweep(7, 3, 140);
    sweep(255, 0, 520);
    sweep(0, 0, 600);
    sweep(1, 8, 1100);
    sweep(1, 15, 1100);

    // R7 stop and resume
    wr(2'd3, 8'd0); wr(2'd1, 8'h00); wr(2'd0, 8'h20);
    repeat (10) @(negedge clk);
    wr(2'd0, 8'h10);
    peek(0, 2'd2, v);
    peek(20, 2'd2, v2);
    check("R7 held during stop", v2, v);
    wr(2'd0, 8'h00);
    peek(7, 2'd2, v2);
    check("R7 resume from held", v2, (v + 7) & 8'hFF);

    // R4 read-then-write-zero
    wr(2'd3, 8'd3); wr(2'd0, 8'h20);
    repeat (10) @(negedge clk);
    wr(2'd0, 8'h10);            // zero write without prior read
    peek(0, 2'd0, v);
    check("R4 flag kept without read", v, 8'h90);
    check("R3 irq off when disabled", irq, 0);
    wr(2'd0, 8'h10);            // zero write after read
    peek(0, 2'd0, v);
    check("R4 flag cleared after read", v, 8'h10);

    // R5 modulo write clears
    wr(2'd0, 8'h20);
    repeat (10) @(negedge clk);
    wr(2'd0, 8'h10);
    peek(0, 2'd0, v); check("R5 flag set before", v, 8'h90);
    wr(2'd3, 8'd3);
    peek(0, 2'd0, v); check("R5 flag cleared", v, 8'h10);

    // R6 restart bit
    wr(2'd0, 8'h60);
    repeat (10) @(negedge clk);
    check("R6 irq before restart", irq, 1);
    wr(2'd0, 8'h30);
    peek(0, 2'd2, v); check("R6 count zero", v, 0);
    peek(0, 2'd0, v); check("R6 flag clear, bit reads 0", v, 8'h10);

    // R10 count write ignored
    wr(2'd3, 8'd0);
    wr(2'd2, 8'h55);
    peek(0, 2'd2, v); check("R10 count write ignored", v, 0);

    // R8 select 01 counts nothing
    wr(2'd1, 8'h10); wr(2'd0, 8'h20);
    peek(30, 2'd2, v); check("R8 select 01 stopped", v, 0);

    // R8 rising edges
    wr(2'd1, 8'h30); wr(2'd0, 8'h20);
    pulse_pin(6);
    peek(5, 2'd2, v); check("R8 rising count", v, 6);

    // R8 falling edges, rise alone not counted
    wr(2'd1, 8'h20); wr(2'd0, 8'h20);
    ext_clk = 1'b1;
    peek(8, 2'd2, v); check("R8 falling ignores rise", v, 0);
    ext_clk = 1'b0;
    peek(8, 2'd2, v); check("R8 falling counted", v, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule